// File: doc/BRIEF.md
# Memory-Mapped BCD Calendar Clock

This block keeps calendar time in BCD: seconds, minutes, hours (24-hour form), day of week, date, month, year and a small binary century count. The time is visible to software as eight bytes at the top of a 13-bit byte address space. One byte is a control register. Seven bytes carry the time fields. Software reads and writes these bytes through plain synchronous ports, and they behave as ordinary storage.

The running counters are hidden. A divider counts a 32768 Hz clock enable down to one tick per second. On each tick the counters advance, and the visible bytes take a fresh copy of the new time. The copy is made only when the control byte allows it. A freeze bit holds the visible copy still, so that software can read several bytes and get a consistent snapshot while the counters keep running. A halt bit also stops the copying. When software clears the halt bit, the counters load whatever it wrote into the time bytes. A six-bit calibration value in the control byte is stored and read back, and it has no effect on timing.

Top module: `rtc_calendar_map`

## Requirements
- R1: After reset the time is 00:00:00, day of week 1, date 01, month 01, year 00, century 0, and the control byte is 00h. The read data output is 00h.
- R2: A read of address BASE_ADDR+k (k = 0..7) returns that byte on `rd_data` one clock later, where k=0 is control, 1 seconds, 2 minutes, 3 hours, 4 day/century, 5 date, 6 month and 7 year. A read of any address outside these eight returns 00h. When `rd_en` is low, `rd_data` is 00h.
- R3: The seconds field advances once for every DIV_RATIO cycles on which `ref_en` is high. Seconds are BCD in bits 6:0 of byte 1.
- R4: Seconds roll from 59 to 00 and carry into minutes (bits 6:0 of byte 2). Minutes roll from 59 to 00 and carry into hours (bits 5:0 of byte 3). Hours roll from 23 to 00 and carry into the next day.
- R5: Each day carry advances the day of week (bits 2:0 of byte 4) from 1 to 7 and then back to 1. When the year rolls from 99 to 00, the two-bit binary century in bits 5:4 of byte 4 increments.
- R6: The date (byte 5) rolls to 01 after day 31 in months 01, 03, 05, 07, 08, 10 and 12, and after day 30 in months 04, 06, 09 and 11. In month 02 it rolls after day 29 when the BCD year is divisible by four, and after day 28 otherwise. Each roll advances the month (byte 6). Month 12 rolls to 01 and advances the year (byte 7).
- R7: When control bits 7 and 6 are both clear, the visible time bytes show the new time on the same edge that the counters advance.
- R8: While control bit 6 (freeze) is set, the visible time bytes do not change except by user writes. The counters keep counting. After bit 6 is cleared, the next tick shows the true current time.
- R9: While control bit 7 (halt) is set, no copy is made. A control write that clears bit 7 while it is set loads the counters from the visible time bytes and restarts the divider from zero.
- R10: The control byte stores all eight written bits. The calibration field (bits 5:0) reads back unchanged and does not affect timing.
- R11: A write to a time byte can be read back at once. A write to a time byte with copying enabled is replaced by the next tick's copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | 32768 Hz clock enable |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 13 | Write byte address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 13 | Read byte address |
| rd_data | output | 8 | Registered read data |

## Verification
A wrong hidden counter does not show at the ports right away. It appears at the next tick that copies the time into the visible bytes, so it can stay hidden for up to one second, and for the whole freeze or halt interval when one of those bits is set. A wrong carry or month-length decision shows only at the rollover that uses it. For this reason the stimulus loads times just before each boundary of interest and reads every byte continuously. A reference model compares each read the cycle after it is issued, so a faulty refresh or load is caught at the first read of the affected byte.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int unsigned SLOTS = 8;
  localparam int unsigned OFF_W = 3;

  typedef struct packed {
    logic [1:0] cent;
    logic [7:0] year;
    logic [4:0] month;
    logic [5:0] date;
    logic [2:0] dow;
    logic [5:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
  } rtc_time_t;

  localparam rtc_time_t TIME_RST = '{cent: 2'd0, year: 8'h00, month: 5'h01,
                                     date: 6'h01, dow: 3'd1, hour: 6'h00,
                                     min: 7'h00, sec: 7'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  function automatic logic is_leap(input logic [7:0] y);
    logic r;
    if (y[4]) r = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      r = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return r;
  endfunction

  function automatic logic [5:0] month_last(input logic [4:0] m, input logic leap);
    logic [5:0] r;
    case (m)
      5'h02:                      r = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: r = 6'h30;
      default:                    r = 6'h31;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] slot_of(input rtc_time_t t, input int unsigned k);
    logic [7:0] r;
    case (k)
      1:       r = {1'b0, t.sec};
      2:       r = {1'b0, t.min};
      3:       r = {2'b0, t.hour};
      4:       r = {2'b0, t.cent, 1'b0, t.dow};
      5:       r = {2'b0, t.date};
      6:       r = {3'b0, t.month};
      7:       r = t.year;
      default: r = 8'h00;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
  parameter int unsigned DIV_RATIO = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_en,
  input  logic clear,
  output logic tick
);
  localparam int unsigned CW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign tick    = ref_en && at_last && !clear;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)        cnt_d = '0;
    else if (ref_en)  cnt_d = at_last ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_cal_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t now_q,
  output rtc_time_t adv
);
  rtc_time_t now_d;
  logic roll_s, roll_m, roll_h, roll_d, roll_mo, roll_y;
  logic [7:0] t_sec, t_min, t_hr, t_date, t_mon, t_year;

  always_comb begin
    roll_s  = (now_q.sec == 7'h59);
    roll_m  = roll_s && (now_q.min == 7'h59);
    roll_h  = roll_m && (now_q.hour == 6'h23);
    roll_d  = roll_h && (now_q.date == month_last(now_q.month, is_leap(now_q.year)));
    roll_mo = roll_d && (now_q.month == 5'h12);
    roll_y  = roll_mo && (now_q.year == 8'h99);

    t_sec  = bcd_inc({1'b0, now_q.sec});
    t_min  = bcd_inc({1'b0, now_q.min});
    t_hr   = bcd_inc({2'b0, now_q.hour});
    t_date = bcd_inc({2'b0, now_q.date});
    t_mon  = bcd_inc({3'b0, now_q.month});
    t_year = bcd_inc(now_q.year);

    adv       = now_q;
    adv.sec   = roll_s ? 7'h00 : t_sec[6:0];
    if (roll_s)  adv.min   = roll_m ? 7'h00 : t_min[6:0];
    if (roll_m)  adv.hour  = roll_h ? 6'h00 : t_hr[5:0];
    if (roll_h)  adv.dow   = (now_q.dow == 3'd7) ? 3'd1 : now_q.dow + 3'd1;
    if (roll_h)  adv.date  = roll_d ? 6'h01 : t_date[5:0];
    if (roll_d)  adv.month = roll_mo ? 5'h01 : t_mon[4:0];
    if (roll_mo) adv.year  = roll_y ? 8'h00 : t_year;
    if (roll_y)  adv.cent  = now_q.cent + 2'd1;
  end

  always_comb begin
    now_d = now_q;
    if (load)      now_d = load_val;
    else if (tick) now_d = adv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now_q <= TIME_RST;
    else        now_q <= now_d;
  end
endmodule

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs
  import rtc_cal_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 13'h1FF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              tick,
  input  rtc_time_t         adv,
  output logic [7:0]        rd_data,
  output logic [7:0]        ctrl_q,
  output logic              load,
  output rtc_time_t         load_val
);
  localparam int unsigned PG_W = ADDR_W - OFF_W;
  localparam logic [PG_W-1:0] PAGE = BASE_ADDR[ADDR_W-1:OFF_W];

  logic [7:0]       vis_q [SLOTS];
  logic [7:0]       vis_d [SLOTS];
  logic             wr_hit, rd_hit, copy_en;
  logic [OFF_W-1:0] wr_slot, rd_slot;
  logic [7:0]       rd_d;

  assign wr_hit  = wr_en && (wr_addr[ADDR_W-1:OFF_W] == PAGE);
  assign rd_hit  = rd_en && (rd_addr[ADDR_W-1:OFF_W] == PAGE);
  assign wr_slot = wr_addr[OFF_W-1:0];
  assign rd_slot = rd_addr[OFF_W-1:0];
  assign ctrl_q  = vis_q[0];
  assign load    = wr_hit && (wr_slot == '0) && vis_q[0][7] && !wr_data[7];
  assign copy_en = tick && !vis_q[0][7] && !vis_q[0][6] && !load;

  assign load_val = '{cent: vis_q[4][5:4], year: vis_q[7], month: vis_q[6][4:0],
                      date: vis_q[5][5:0], dow: vis_q[4][2:0], hour: vis_q[3][5:0],
                      min: vis_q[2][6:0], sec: vis_q[1][6:0]};

  always_comb begin
    for (int unsigned k = 0; k < SLOTS; k++) begin
      vis_d[k] = vis_q[k];
      if (copy_en && k != 0)                 vis_d[k] = slot_of(adv, k);
      if (wr_hit && wr_slot == OFF_W'(k))    vis_d[k] = wr_data;
    end
    rd_d = rd_hit ? vis_q[rd_slot] : 8'h00;
  end

  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vis_q[g] <= slot_of(TIME_RST, g);
        else        vis_q[g] <= vis_d[g];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= 8'h00;
    else        rd_data <= rd_d;
  end
endmodule

// File: rtl/rtc_calendar_map.sv
module rtc_calendar_map
  import rtc_cal_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 13'h1FF8,
  parameter int unsigned DIV_RATIO = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       tick, load;
  logic [7:0] ctrl_q;
  rtc_time_t  now_q, adv, load_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  rtc_tick_div #(.DIV_RATIO(DIV_RATIO)) u_div (
    .clk(clk), .rst_n(rst_core_n), .ref_en(ref_en), .clear(load), .tick(tick)
  );

  rtc_time_chain u_chain (
    .clk(clk), .rst_n(rst_core_n), .tick(tick), .load(load),
    .load_val(load_val), .now_q(now_q), .adv(adv)
  );

  rtc_shadow_regs #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .tick(tick),
    .adv(adv), .rd_data(rd_data), .ctrl_q(ctrl_q), .load(load),
    .load_val(load_val)
  );
endmodule

// File: rtl/rtc_calendar_map_chk.sv
module rtc_calendar_map_chk
  import rtc_cal_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 13'h1FF8
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [7:0]        rd_data,
  input logic              wr_en,
  input logic              tick,
  input logic              load,
  input logic [7:0]        ctrl_q,
  input rtc_time_t         now_q,
  input rtc_time_t         load_val
);
  logic rd_out;
  assign rd_out = rd_en && (rd_addr[ADDR_W-1:OFF_W] != BASE_ADDR[ADDR_W-1:OFF_W]);

  AST_RD_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_core_n)
    rd_out |=> (rd_data == 8'h00));  // R2
  AST_SEC_ADVANCES: assert property (@(posedge clk) disable iff (!rst_core_n)
    (tick && !load) |=> (now_q.sec != $past(now_q.sec)));  // R3
  AST_SEC_BCD: assert property (@(posedge clk) disable iff (!rst_core_n)
    (now_q.sec[3:0] <= 4'd9) && (now_q.sec[6:4] <= 3'd5));  // R3
  AST_HOUR_RANGE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (now_q.hour[3:0] <= 4'd9) && (now_q.hour <= 6'h23));  // R4
  AST_DOW_RANGE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (now_q.dow != 3'd0));  // R5
  AST_DATE_NONZERO: assert property (@(posedge clk) disable iff (!rst_core_n)
    (now_q.date != 6'h00) && (now_q.month != 5'h00));  // R6
  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ctrl_q[6] && !wr_en) |=> $stable(load_val));  // R8
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ctrl_q[7] && !wr_en) |=> $stable(load_val));  // R9
  AST_LOAD_TAKES_COPY: assert property (@(posedge clk) disable iff (!rst_core_n)
    load |=> (now_q == $past(load_val)));  // R9
endmodule

bind rtc_calendar_map rtc_calendar_map_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk(clk), .rst_core_n(rst_core_n), .rd_en(rd_en), .rd_addr(rd_addr),
  .rd_data(rd_data), .wr_en(wr_en), .tick(tick), .load(load),
  .ctrl_q(ctrl_q), .now_q(now_q), .load_val(load_val)
);

// File: tb/rtc_calendar_map_bench.sv
module rtc_calendar_map_bench;
  localparam int DIV = 4;
  localparam logic [12:0] BASE = 13'h1FF8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_en = 1'b0;
  logic wr_en = 1'b0;
  logic [12:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic rd_en = 1'b0;
  logic [12:0] rd_addr = '0;
  logic [7:0]  rd_data;

  int checks = 0;
  int failures = 0;
  string req = "R1";
  bit ref_run = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_calendar_map #(.DIV_RATIO(DIV)) u_rtc_calendar_map (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // reference model (decimal integers)
  int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr, m_cent, m_pre;
  logic [7:0] m_vis [8];
  logic [7:0] exp_rd;
  bit pend;

  function automatic logic [7:0] bcd(int v);
    return 8'((v / 10) * 16 + v % 10);
  endfunction
  function automatic int dec(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic int days_in(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_reset();
    m_sec = 0; m_min = 0; m_hr = 0; m_dow = 1; m_date = 1; m_mon = 1;
    m_yr = 0; m_cent = 0; m_pre = 0; pend = 1'b0; exp_rd = 8'h00;
    m_vis[0] = 8'h00; m_vis[1] = 8'h00; m_vis[2] = 8'h00; m_vis[3] = 8'h00;
    m_vis[4] = 8'h01; m_vis[5] = 8'h01; m_vis[6] = 8'h01; m_vis[7] = 8'h00;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      bit whit, ld, tk;
      logic [7:0] c0;
      c0 = m_vis[0];
      whit = wr_en && (wr_addr >= BASE) && (wr_addr <= BASE + 13'd7);
      ld = whit && (wr_addr == BASE) && c0[7] && !wr_data[7];
      tk = !ld && ref_en && (m_pre == DIV - 1);
      if (ld) m_pre = 0;
      else if (ref_en) m_pre = (m_pre == DIV - 1) ? 0 : m_pre + 1;
      pend = rd_en;
      exp_rd = (rd_en && rd_addr >= BASE && rd_addr <= BASE + 13'd7) ? m_vis[rd_addr - BASE] : 8'h00;
      if (ld) begin
        m_sec = dec({1'b0, m_vis[1][6:0]}); m_min = dec({1'b0, m_vis[2][6:0]});
        m_hr = dec({2'b0, m_vis[3][5:0]}); m_dow = int'(m_vis[4][2:0]);
        m_cent = int'(m_vis[4][5:4]); m_date = dec({2'b0, m_vis[5][5:0]});
        m_mon = dec({3'b0, m_vis[6][4:0]}); m_yr = dec(m_vis[7]);
      end else if (tk) begin
        m_sec++;
        if (m_sec == 60) begin m_sec = 0; m_min++; end
        if (m_min == 60) begin m_min = 0; m_hr++; end
        if (m_hr == 24) begin
          m_hr = 0; m_dow = (m_dow == 7) ? 1 : m_dow + 1; m_date++;
          if (m_date > days_in(m_mon, m_yr)) begin m_date = 1; m_mon++; end
          if (m_mon == 13) begin m_mon = 1; m_yr++; end
          if (m_yr == 100) begin m_yr = 0; m_cent = (m_cent + 1) % 4; end
        end
      end
      if (tk && !c0[7] && !c0[6]) begin
        m_vis[1] = bcd(m_sec); m_vis[2] = bcd(m_min); m_vis[3] = bcd(m_hr);
        m_vis[4] = 8'(m_cent * 16 + m_dow); m_vis[5] = bcd(m_date);
        m_vis[6] = bcd(m_mon); m_vis[7] = bcd(m_yr);
      end
      if (whit) m_vis[wr_addr - BASE] = wr_data;
    end
  end

  always @(negedge clk) begin
    if (rst_n && pend && !done) begin
      checks++;
      if (rd_data !== exp_rd) begin
        failures++;
        $display("FAIL %s: rd_data=%02h expected %02h at %0t", req, rd_data, exp_rd, $time);
      end
    end
  end

  // 32768 Hz enable stand-in: high two cycles of three
  int ref_phase = 0;
  always @(negedge clk) begin
    ref_phase = (ref_phase + 1) % 3;
    ref_en <= ref_run && (ref_phase != 0);
  end

  task automatic wr(logic [12:0] a, logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_en = 1'b1;
      rd_addr = (i % 9 == 8) ? 13'h0123 : BASE + 13'(i % 9);
    end
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_time(logic [7:0] s, logic [7:0] mi, logic [7:0] h, logic [7:0] dc,
                          logic [7:0] d, logic [7:0] mo, logic [7:0] y);
    wr(BASE, 8'h80);
    wr(BASE + 13'd1, s); wr(BASE + 13'd2, mi); wr(BASE + 13'd3, h);
    wr(BASE + 13'd4, dc); wr(BASE + 13'd5, d); wr(BASE + 13'd6, mo);
    wr(BASE + 13'd7, y);
    wr(BASE, 8'h00);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    req = "R1";
    checks++;
    if (rd_data !== 8'h00) begin
      failures++;
      $display("FAIL R1: rd_data=%02h expected 00", rd_data);
    end
    run(18);
    ref_run = 1'b1;
    req = "R3"; run(60);
    req = "R2"; run(27);
    req = "R4"; set_time(8'h55, 8'h59, 8'h23, 8'h17, 8'h31, 8'h12, 8'h99); run(80);
    req = "R5"; set_time(8'h57, 8'h59, 8'h23, 8'h37, 8'h31, 8'h12, 8'h99); run(60);
    req = "R6"; set_time(8'h58, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h21); run(40);
    set_time(8'h58, 8'h59, 8'h23, 8'h03, 8'h31, 8'h01, 8'h21); run(40);
    set_time(8'h58, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23); run(40);
    set_time(8'h58, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24); run(40);
    set_time(8'h58, 8'h59, 8'h23, 8'h03, 8'h29, 8'h02, 8'h24); run(40);
    set_time(8'h58, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h00); run(40);
    set_time(8'h58, 8'h59, 8'h23, 8'h03, 8'h30, 8'h11, 8'h50); run(40);
    req = "R7"; run(30);
    req = "R8"; wr(BASE, 8'h55); run(70);
    wr(BASE, 8'h15); run(40);
    req = "R10"; wr(BASE, 8'h2A); run(45);
    req = "R9"; wr(BASE, 8'hBF); run(50);
    wr(BASE + 13'd2, 8'h42); wr(BASE, 8'h3F); run(50);
    req = "R11"; wr(BASE + 13'd3, 8'h07); run(3); run(40);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule